// File: doc/BRIEF.md
# Gated charge integration sequencer

The block runs one acquisition for each trigger pulse. The trigger opens an integration gate whose length is programmable in clock ticks. The block picks one sample from a parallel ADC stream at a programmable delay after the gate opens. This is the start point. It picks a second sample at a programmable delay after the gate has closed. This is the stop point. The ADC stream is synchronous to the system clock.

A three-bit mode sets what the block emits on a valid-strobed result bus. It can emit:
- the saturated stop-minus-start difference,
- the stop point alone,
- the start point alone,
- both points, one after the other,
- or every sample from the start point through the stop point.

Each emitted word is also kept in a last-value register. Software reads that register through a small register port. The same port is used to program the gate length, both delays and the mode. All four settings are copied at the trigger, so later writes only affect the next acquisition.

Top module: `cgs_top`

## Requirements
- R1: After reset, and at any time without a trigger, res_valid stays low. An acquisition starts only on a clock edge where trig is high while the block is idle. At that edge the gate length, start delay, stop delay and mode are copied. Call that edge E0. "Emitted at edge e" means that res_valid is high and res_data holds the word during the cycle that follows edge e.
- R2: The start point is the adc_data value sampled at edge S = E0 + 1 + Ds, where Ds is the 8-bit start delay in ticks.
- R3: The stop point is the adc_data value sampled at edge P = E0 + 1 + T, where T = max(G' + Dp, Ds + 1). G' is the 16-bit gate length, with a length of 0 counted as 1. Dp is the 8-bit stop delay. The stop point therefore always comes after the start point.
- R4: Mode 0 (code 000) emits a single word at edge P: stop minus start, as a signed value. The result is clamped to the 15-bit range -16384..16383 and sign-extended to 16 bits.
- R5: Mode 1 (code 001) emits only the stop point, at edge P. Mode 2 (code 010) emits only the start point, at edge S.
- R6: Mode 3 (code 011) emits the start point at edge P and then the stop point at edge P + 1.
- R7: Mode 4 (code 100) emits adc_data at every edge from S through P inclusive, so T - Ds + 1 words in total.
- R8: Modes 5 to 7 emit nothing, but the sequence still runs to edge P. A trigger sampled at edge P + 1 starts the next acquisition.
- R9: A trigger that arrives while an acquisition is running is ignored. It neither restarts the acquisition nor adds any output.
- R10: Register address 4 reads the last word emitted. It is updated one clock after each emitted word and reads 0 after reset.
- R11: Address 0 holds the gate length in bits 15:0. Address 1 holds the start delay in bits 7:0. Address 2 holds the stop delay in bits 7:0. Address 3 holds the mode in bits 2:0. Each is written by wr_en at a clock edge and read back through rd_addr/rd_data combinationally. All reset to 0, and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Acquisition trigger, sampled at clock edges |
| adc_data | input | 16 | Parallel ADC sample stream |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| res_valid | output | 1 | Result word valid strobe |
| res_data | output | 16 | Result word |

## Verification
Every result is due one cycle after a fixed edge, counted from the trigger edge E0:
- A start-point word follows edge E0 + 1 + Ds.
- A stop or difference word follows edge E0 + 1 + T.
- The second word of a pair follows one edge later.
- Waveform words follow each edge from the start point to the stop point.

The bench numbers every clock edge. It logs the ADC value it drives ahead of each edge and records each valid result together with the edge it belongs to. After each acquisition it compares that record with a list built from the logged samples and the formulas for S and T, checking the count, the edges and the values. The last-value register is read well after the final word, so the one-clock update delay is always over.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_EMIT2 = 2'd2
   } seq_state_t;

   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MD_DIFF  = 3'd0;
   localparam logic [MODE_W-1:0] MD_STOP  = 3'd1;
   localparam logic [MODE_W-1:0] MD_START = 3'd2;
   localparam logic [MODE_W-1:0] MD_PAIR  = 3'd3;
   localparam logic [MODE_W-1:0] MD_WAVE  = 3'd4;

   localparam int RA_GATE = 0;
   localparam int RA_SDLY = 1;
   localparam int RA_PDLY = 2;
   localparam int RA_MODE = 3;
   localparam int RA_LAST = 4;

endpackage

// File: rtl/cgs_regs.sv
module cgs_regs
   import cgs_pkg::*;
#(
   parameter int GW = 16,
   parameter int DW = 8,
   parameter int OW = 16,
   parameter int AW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [OW-1:0]        wr_data,
   input  logic [AW-1:0]        rd_addr,
   output logic [OW-1:0]        rd_data,
   input  logic [OW-1:0]        last_val,
   output logic [GW-1:0]        gate_o,
   output logic [DW-1:0]        sdly_o,
   output logic [DW-1:0]        pdly_o,
   output logic [MODE_W-1:0]    mode_o
);

   if (GW > OW) begin : g_chk_gw
      $error("cgs_regs: gate width exceeds register width");
   end
   if (DW > OW) begin : g_chk_dw
      $error("cgs_regs: delay width exceeds register width");
   end
   if (AW < 3) begin : g_chk_aw
      $error("cgs_regs: address too narrow for the register map");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_o <= '0;
         sdly_o <= '0;
         pdly_o <= '0;
         mode_o <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            AW'(RA_GATE): gate_o <= wr_data[GW-1:0];
            AW'(RA_SDLY): sdly_o <= wr_data[DW-1:0];
            AW'(RA_PDLY): pdly_o <= wr_data[DW-1:0];
            AW'(RA_MODE): mode_o <= wr_data[MODE_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         AW'(RA_GATE): rd_data = OW'(gate_o);
         AW'(RA_SDLY): rd_data = OW'(sdly_o);
         AW'(RA_PDLY): rd_data = OW'(pdly_o);
         AW'(RA_MODE): rd_data = OW'(mode_o);
         AW'(RA_LAST): rd_data = last_val;
         default:      rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cgs_seq.sv
module cgs_seq
   import cgs_pkg::*;
#(
   parameter int GW = 16,
   parameter int DW = 8,
   parameter int SW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [SW-1:0]     adc,
   input  logic [GW-1:0]     gate,
   input  logic [DW-1:0]     sdly,
   input  logic [DW-1:0]     pdly,
   input  logic [MODE_W-1:0] mode,
   output seq_state_t        state_o,
   output logic [MODE_W-1:0] mode_q,
   output logic              at_start,
   output logic              at_stop,
   output logic              in_win,
   output logic [SW-1:0]     start_q,
   output logic [SW-1:0]     stop_q
);

   localparam int TW = ((GW > DW) ? GW : DW) + 2;

   logic [TW-1:0] tick_q;
   logic [TW-1:0] sdly_q;
   logic [TW-1:0] stop_t_q;
   logic [GW-1:0] gate_eff;
   logic [TW-1:0] late_t;
   logic [TW-1:0] early_t;
   logic [TW-1:0] stop_calc;
   logic          running;

   always_comb begin
      gate_eff  = (gate == '0) ? GW'(1) : gate;
      late_t    = TW'(gate_eff) + TW'(pdly);
      early_t   = TW'(sdly) + TW'(1);
      stop_calc = (late_t > early_t) ? late_t : early_t;
   end

   assign running  = (state_o == ST_RUN);
   assign at_start = running && (tick_q == sdly_q);
   assign at_stop  = running && (tick_q == stop_t_q);
   assign in_win   = running && (tick_q >= sdly_q) && (tick_q <= stop_t_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_o  <= ST_IDLE;
         mode_q   <= '0;
         tick_q   <= '0;
         sdly_q   <= '0;
         stop_t_q <= '0;
         start_q  <= '0;
         stop_q   <= '0;
      end else begin
         case (state_o)
            ST_IDLE: begin
               if (trig) begin
                  tick_q   <= '0;
                  sdly_q   <= TW'(sdly);
                  stop_t_q <= stop_calc;
                  mode_q   <= mode;
                  state_o  <= ST_RUN;
               end
            end
            ST_RUN: begin
               tick_q <= tick_q + TW'(1);
               if (at_start) start_q <= adc;
               if (at_stop) begin
                  stop_q  <= adc;
                  state_o <= (mode_q == MD_PAIR) ? ST_EMIT2 : ST_IDLE;
               end
            end
            ST_EMIT2: state_o <= ST_IDLE;
            default:  state_o <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cgs_fmt.sv
module cgs_fmt
   import cgs_pkg::*;
#(
   parameter int SW       = 16,
   parameter int OW       = 16,
   parameter int DIFF_W   = 15,
   parameter bit SAT_DIFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state,
   input  logic [MODE_W-1:0] mode_q,
   input  logic              at_start,
   input  logic              at_stop,
   input  logic              in_win,
   input  logic [SW-1:0]     adc,
   input  logic [SW-1:0]     start_q,
   input  logic [SW-1:0]     stop_q,
   output logic              res_valid,
   output logic [OW-1:0]     res_data,
   output logic [OW-1:0]     last_val
);

   localparam int XW = SW + 2;

   logic signed [XW-1:0] dx;
   logic [OW-1:0]        diff_word;

   assign dx = $signed({2'b00, adc}) - $signed({2'b00, start_q});

   if (SAT_DIFF) begin : g_sat
      localparam logic signed [XW-1:0] DMAX = XW'((1 << (DIFF_W - 1)) - 1);
      localparam logic signed [XW-1:0] DMIN = -DMAX - XW'(1);
      logic signed [XW-1:0] dsel;
      always_comb begin
         if (dx > DMAX)      dsel = DMAX;
         else if (dx < DMIN) dsel = DMIN;
         else                dsel = dx;
      end
      assign diff_word = OW'(dsel);
   end else begin : g_wrap
      logic signed [DIFF_W-1:0] dn;
      assign dn        = dx[DIFF_W-1:0];
      assign diff_word = OW'(dn);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         last_val  <= '0;
      end else begin
         res_valid <= 1'b0;
         if (res_valid) last_val <= res_data;
         case (mode_q)
            MD_DIFF: if (at_stop) begin
               res_valid <= 1'b1;
               res_data  <= diff_word;
            end
            MD_STOP: if (at_stop) begin
               res_valid <= 1'b1;
               res_data  <= OW'(adc);
            end
            MD_START: if (at_start) begin
               res_valid <= 1'b1;
               res_data  <= OW'(adc);
            end
            MD_PAIR: begin
               if (at_stop) begin
                  res_valid <= 1'b1;
                  res_data  <= OW'(start_q);
               end else if (state == ST_EMIT2) begin
                  res_valid <= 1'b1;
                  res_data  <= OW'(stop_q);
               end
            end
            MD_WAVE: if (in_win) begin
               res_valid <= 1'b1;
               res_data  <= OW'(adc);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cgs_top.sv
module cgs_top
   import cgs_pkg::*;
#(
   parameter int SW       = 16,
   parameter int OW       = 16,
   parameter int GW       = 16,
   parameter int DW       = 8,
   parameter int DIFF_W   = 15,
   parameter int AW       = 3,
   parameter bit SAT_DIFF = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [SW-1:0] adc_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [OW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [OW-1:0] rd_data,
   output logic          res_valid,
   output logic [OW-1:0] res_data
);

   if (SW > OW) begin : g_chk_sw
      $error("cgs_top: sample wider than result word");
   end
   if (DIFF_W > OW || DIFF_W < 2 || DIFF_W > SW + 1) begin : g_chk_diff
      $error("cgs_top: difference width out of range");
   end

   logic [GW-1:0]     cfg_gate;
   logic [DW-1:0]     cfg_sdly;
   logic [DW-1:0]     cfg_pdly;
   logic [MODE_W-1:0] cfg_mode;
   logic [MODE_W-1:0] snap_mode;
   seq_state_t        seq_state;
   logic              at_start;
   logic              at_stop;
   logic              in_win;
   logic [SW-1:0]     start_s;
   logic [SW-1:0]     stop_s;
   logic [OW-1:0]     last_val;

   cgs_regs #(.GW(GW), .DW(DW), .OW(OW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .last_val(last_val), .gate_o(cfg_gate), .sdly_o(cfg_sdly),
      .pdly_o(cfg_pdly), .mode_o(cfg_mode)
   );

   cgs_seq #(.GW(GW), .DW(DW), .SW(SW)) u_seq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .adc(adc_data),
      .gate(cfg_gate), .sdly(cfg_sdly), .pdly(cfg_pdly), .mode(cfg_mode),
      .state_o(seq_state), .mode_q(snap_mode), .at_start(at_start),
      .at_stop(at_stop), .in_win(in_win), .start_q(start_s), .stop_q(stop_s)
   );

   cgs_fmt #(.SW(SW), .OW(OW), .DIFF_W(DIFF_W), .SAT_DIFF(SAT_DIFF)) u_fmt (
      .clk(clk), .rst_n(rst_n), .state(seq_state), .mode_q(snap_mode),
      .at_start(at_start), .at_stop(at_stop), .in_win(in_win),
      .adc(adc_data), .start_q(start_s), .stop_q(stop_s),
      .res_valid(res_valid), .res_data(res_data), .last_val(last_val)
   );

endmodule

// File: rtl/cgs_chk.sv
module cgs_chk
   import cgs_pkg::*;
#(
   parameter int OW     = 16,
   parameter int DIFF_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic [OW-1:0]     res_data,
   input seq_state_t        state,
   input logic [MODE_W-1:0] mode_q,
   input logic [OW-1:0]     last_q
);

   // R1: no output while the sequencer rests in idle
   a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_IDLE) |-> !res_valid);

   // R4: difference words always fit the sign-extended narrow range
   a_r4_diff_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && mode_q == MD_DIFF) |->
      (res_data[OW-1:DIFF_W-1] == '0 || res_data[OW-1:DIFF_W-1] == '1));

   // R6: the second pair word follows the pair state
   a_r6_pair_second: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EMIT2) |=> res_valid);

   // R8: reserved modes stay silent
   a_r8_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && mode_q > MD_WAVE) |=> !res_valid);

   // R10: the last-value register follows each emitted word
   a_r10_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (last_q == $past(res_data)));

endmodule

bind cgs_top cgs_chk #(.OW(OW), .DIFF_W(DIFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
   .state(seq_state), .mode_q(snap_mode), .last_q(last_val)
);

// File: tb/sim_cgs_top.sv
module sim_cgs_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig = 1'b0;
   logic [15:0] adc_data = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        res_valid;
   logic [15:0] res_data;

   int n_checks = 0;
   int n_fail = 0;
   int ecnt = 0;
   bit finished = 1'b0;

   logic [15:0] adc_log [int];
   int          got_e [$];
   logic [15:0] got_d [$];

   cgs_top u0 (
      .clk(clk), .rst_n(rst_n), .trig(trig), .adc_data(adc_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .res_valid(res_valid), .res_data(res_data)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) ecnt <= ecnt + 1;

   always @(negedge clk) begin
      logic [15:0] v;
      v = 16'($urandom);
      adc_data = v;
      adc_log[ecnt + 1] = v;
      if (rst_n && res_valid) begin
         got_e.push_back(ecnt);
         got_d.push_back(res_data);
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 3'(addr);
      wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int addr, output int val);
      @(negedge clk);
      rd_addr = 3'(addr);
      #1;
      val = int'(rd_data);
   endtask

   task automatic cfg(input int g, input int ds, input int dp, input int md);
      wr(0, g);
      wr(1, ds);
      wr(2, dp);
      wr(3, md);
   endtask

   task automatic wait_until(input int e);
      while (ecnt < e) @(negedge clk);
   endtask

   task automatic fire(output int e0);
      @(negedge clk);
      trig = 1'b1;
      e0 = ecnt + 1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   function automatic int stopt(input int g, input int ds, input int dp);
      int ge;
      ge = (g == 0) ? 1 : g;
      return (ge + dp > ds + 1) ? ge + dp : ds + 1;
   endfunction

   function automatic logic [15:0] sat15(input int a, input int b);
      int d;
      d = b - a;
      if (d > 16383) d = 16383;
      if (d < -16384) d = -16384;
      return 16'(d);
   endfunction

   function automatic string mode_tag(input int md);
      case (md)
         0: return "R2 R3 R4";
         1: return "R3 R5";
         2: return "R2 R5";
         3: return "R2 R3 R6";
         4: return "R2 R3 R7";
         default: return "R8";
      endcase
   endfunction

   task automatic verify(input int e0, input int g, input int ds, input int dp,
                         input int md, input string extra);
      int          ee [$];
      logic [15:0] ed [$];
      int s;
      int p;
      int nmin;
      int lv;
      string tag;
      s = e0 + 1 + ds;
      p = e0 + 1 + stopt(g, ds, dp);
      tag = {mode_tag(md), extra};
      case (md)
         0: begin ee.push_back(p); ed.push_back(sat15(int'(adc_log[s]), int'(adc_log[p]))); end
         1: begin ee.push_back(p); ed.push_back(adc_log[p]); end
         2: begin ee.push_back(s); ed.push_back(adc_log[s]); end
         3: begin
            ee.push_back(p);     ed.push_back(adc_log[s]);
            ee.push_back(p + 1); ed.push_back(adc_log[p]);
         end
         4: for (int e = s; e <= p; e++) begin ee.push_back(e); ed.push_back(adc_log[e]); end
         default: ;
      endcase
      check(got_e.size() == ee.size(), {tag, " word count"}, got_e.size(), ee.size());
      nmin = (got_e.size() < ee.size()) ? got_e.size() : ee.size();
      for (int i = 0; i < nmin; i++) begin
         check(got_e[i] == ee[i], {tag, " edge"}, got_e[i], ee[i]);
         check(got_d[i] == ed[i], {tag, " data"}, int'(got_d[i]), int'(ed[i]));
      end
      if (ee.size() > 0) begin
         rd(4, lv);
         check(lv == int'(ed[ed.size() - 1]), "R10 last value", lv, int'(ed[ed.size() - 1]));
      end
   endtask

   task automatic run_one(input int g, input int ds, input int dp, input int md,
                          input bit busy);
      int e0;
      int p;
      cfg(g, ds, dp, md);
      got_e.delete();
      got_d.delete();
      fire(e0);
      p = e0 + 1 + stopt(g, ds, dp);
      if (busy && (p - e0 >= 5)) begin
         wait_until(e0 + 2);
         @(negedge clk);
         trig = 1'b1;
         @(negedge clk);
         trig = 1'b0;
      end
      wait_until(p + 4);
      verify(e0, g, ds, dp, md, busy ? " R9" : "");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", ecnt, 0);
         report();
      end
   end

   initial begin
      int v;
      int ea;
      int pa;
      int eb;
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 and R10: reset values
      for (int a = 0; a < 5; a++) begin
         rd(a, v);
         check(v == 0, (a == 4) ? "R10 reset last" : "R11 reset value", v, 0);
      end

      // R11: write and read back
      cfg(16'hA5C3, 8'h7E, 8'h81, 5);
      rd(0, v); check(v == 16'hA5C3, "R11 gate readback", v, 16'hA5C3);
      rd(1, v); check(v == 8'h7E, "R11 start delay readback", v, 8'h7E);
      rd(2, v); check(v == 8'h81, "R11 stop delay readback", v, 8'h81);
      rd(3, v); check(v == 5, "R11 mode readback", v, 5);
      rd(6, v); check(v == 0, "R11 unmapped address", v, 0);

      // R1: no trigger, no output
      cfg(3, 0, 0, 4);
      got_e.delete();
      got_d.delete();
      repeat (30) @(negedge clk);
      check(got_e.size() == 0, "R1 idle without trigger", got_e.size(), 0);

      // directed corners
      run_one(10, 2, 3, 0, 1'b0);
      run_one(0, 0, 0, 3, 1'b0);    // R3 zero gate counts as one tick
      run_one(2, 6, 1, 4, 1'b0);    // R3 start delay past gate end
      run_one(0, 0, 0, 4, 1'b0);
      run_one(5, 0, 0, 2, 1'b0);
      run_one(20, 3, 4, 1, 1'b1);   // R9 retrigger while running
      run_one(12, 1, 2, 3, 1'b1);   // R9 in pair mode

      // R8: reserved mode runs to its stop edge, then a back-to-back trigger
      cfg(40, 2, 3, 5);
      got_e.delete();
      got_d.delete();
      fire(ea);
      pa = ea + 1 + stopt(40, 2, 3);
      cfg(2, 0, 1, 1);
      wait_until(pa);
      trig = 1'b1;
      eb = ecnt + 1;
      @(negedge clk);
      trig = 1'b0;
      wait_until(eb + 1 + stopt(2, 0, 1) + 4);
      verify(eb, 2, 0, 1, 1, " R8 back-to-back");

      // random mix
      for (int k = 0; k < 40; k++) begin
         int g;
         int ds;
         int dp;
         int md;
         g = $urandom_range(0, 30);
         ds = $urandom_range(0, 20);
         dp = $urandom_range(0, 20);
         md = ($urandom_range(0, 9) == 0) ? $urandom_range(5, 7) : $urandom_range(0, 4);
         run_one(g, ds, dp, md, ($urandom_range(0, 3) == 0));
      end

      finished = 1'b1;
      report();
   end

endmodule